// File: doc/BRIEF.md
# Asynchronous DRAM Strobe Sequencer

This block turns single-word processor requests into the strobe sequence an asynchronous DRAM needs. The processor offers a flat byte address, a direction bit (1 = read, 0 = write), write data and a one-cycle request pulse. When the access ends, the block raises a completion pulse, and for reads it presents the fetched byte on a held output. On the memory side the block splits the address into a row part (upper bits) and a column part (lower bits). It places the two parts one after the other on a shared address bus and drives four active-low controls: row strobe, column strobe, write enable and output enable.

Each phase lasts a number of clock cycles set by a parameter. This covers address setup before a strobe, address hold after it, data access time from the column strobe, and precharge after the row strobe rises. An input selects whether output enable goes low before the column strobe or only after it. After an access the row stays open. A later request to the same row skips the row phase and issues only a new column address and column strobe. A request to a different row first closes the open row and waits out the precharge. While an access is in flight, request pulses are ignored. Refresh is not handled here.

With default parameters the address is 21 bits: 12 row bits select one of 4096 rows and 9 column bits select one of 512 bytes within the row.

Top module: `dram_timing_ctrl`

## Requirements
- R1: While reset is held and just after it, all four memory strobes are high (inactive), the write-data drive enable is low and the completion output is low.
- R2: The row address is the upper ROW_BITS of the request address and the column address is the lower COL_BITS. The row address is on the bus when the row strobe falls and the column address is on the bus when the column strobe falls. The column strobe is low only while the row strobe is low.
- R3: The row address is on the bus for at least ROW_SETUP cycles with the row strobe high before the row strobe falls. It stays unchanged for at least ROW_HOLD cycles with the row strobe low.
- R4: The column address is on the bus for at least COL_SETUP cycles before the column strobe falls. The column strobe stays low for max(COL_HOLD, ACCESS_CYC) cycles with the column address held.
- R5: With lateRead = 0, a read drives output enable low at least one cycle before the column strobe falls.
- R6: With lateRead = 1, a read keeps output enable high in the first cycle of column strobe low and drives it low from the next cycle.
- R7: A read (reqRw = 1) captures the data input ACCESS_CYC cycles after the column strobe falls. The captured value stays on rdData until the next read completes, and a write leaves it unchanged.
- R8: A write (reqRw = 0) holds write enable low and drives the request data, with the drive enable high, from column setup through column strobe low. Output enable stays high during a write.
- R9: Completion is a one-cycle pulse. For an access that starts with no row open, the pulse appears 1+ROW_SETUP+ROW_HOLD+COL_SETUP+max(COL_HOLD,ACCESS_CYC) cycles after the accepting edge.
- R10: A request to the row that is already open keeps the row strobe low with no rise. It completes 1+COL_SETUP+max(COL_HOLD,ACCESS_CYC) cycles after the accepting edge.
- R11: A request to a different row raises the row strobe for at least PRECHARGE_CYC cycles before the new row phase. It completes PRECHARGE_CYC cycles later than an access that starts with no row open.
- R12: A request pulse that arrives while an access is in flight is ignored. It causes no completion and no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | One-cycle request pulse |
| reqRw | input | 1 | 1 = read, 0 = write |
| reqAddr | input | ROW_BITS+COL_BITS | Flat byte address |
| reqWdata | input | DATA_BITS | Write data |
| lateRead | input | 1 | 1 = output enable after column strobe, 0 = before |
| rdData | output | DATA_BITS | Last byte read, held |
| mfc | output | 1 | Access-complete pulse |
| dramAddr | output | max(ROW_BITS,COL_BITS) | Multiplexed row/column address |
| dramRasN | output | 1 | Row strobe, active low |
| dramCasN | output | 1 | Column strobe, active low |
| dramWeN | output | 1 | Write enable, active low |
| dramOeN | output | 1 | Output enable, active low |
| dramDout | output | DATA_BITS | Write data to memory |
| dramDoutEn | output | 1 | Write data drive enable |
| dramDin | input | DATA_BITS | Read data from memory |

## Verification
A stale open-row register shows up on the very next request as a page hit that skips the row strobe. That access completes early and returns a byte from the wrong row, and the sweep of every address catches it on the first read. A phase counter loaded with the wrong value moves the completion pulse by a cycle and shortens a setup or hold window, and this is visible on the first access after reset. An error in the output-enable ordering appears on the column strobe's falling edge in whichever read mode it affects.

// File: rtl/dram_timing_pkg.sv
package dram_timing_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRECHG,
    ST_ROW_SETUP,
    ST_ROW_HOLD,
    ST_COL_SETUP,
    ST_CAS_LOW,
    ST_DONE,
    ST_ROW_OPEN
  } ctlState_t;

  // strobes from the sequencer to the address/data path
  typedef struct packed {
    logic latchReq;
    logic selCol;
    logic captureData;
  } dpStrobes_t;

endpackage

// File: rtl/dram_timing_dp.sv
module dram_timing_dp
  import dram_timing_pkg::*;
#(
  parameter int ROW_BITS  = 12,
  parameter int COL_BITS  = 9,
  parameter int DATA_BITS = 8,
  parameter int MUX_BITS  = 12
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dpStrobes_t                    strobes,
  input  logic                          reqRw,
  input  logic [ROW_BITS+COL_BITS-1:0]  reqAddr,
  input  logic [DATA_BITS-1:0]          reqWdata,
  input  logic                          lateRead,
  input  logic [DATA_BITS-1:0]          dramDin,
  output logic                          rowHit,
  output logic                          curRead,
  output logic                          curLate,
  output logic [MUX_BITS-1:0]           dramAddr,
  output logic [DATA_BITS-1:0]          dramDout,
  output logic [DATA_BITS-1:0]          rdData
);
  localparam int ADDR_BITS = ROW_BITS + COL_BITS;

  logic [ROW_BITS-1:0]  rowReg;
  logic [COL_BITS-1:0]  colReg;
  logic [DATA_BITS-1:0] wdataReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowReg   <= '0;
      colReg   <= '0;
      wdataReg <= '0;
      curRead  <= 1'b1;
      curLate  <= 1'b0;
      rdData   <= '0;
    end else begin
      if (strobes.latchReq) begin
        rowReg   <= reqAddr[ADDR_BITS-1:COL_BITS];
        colReg   <= reqAddr[COL_BITS-1:0];
        wdataReg <= reqWdata;
        curRead  <= reqRw;
        curLate  <= lateRead;
      end
      if (strobes.captureData) rdData <= dramDin;
    end
  end

  // compared against the row left open by the previous access
  assign rowHit   = (reqAddr[ADDR_BITS-1:COL_BITS] == rowReg);
  assign dramAddr = strobes.selCol ? MUX_BITS'(colReg) : MUX_BITS'(rowReg);
  assign dramDout = wdataReg;

endmodule

// File: rtl/dram_timing_fsm.sv
module dram_timing_fsm
  import dram_timing_pkg::*;
#(
  parameter int ROW_SETUP     = 1,
  parameter int ROW_HOLD      = 1,
  parameter int COL_SETUP     = 1,
  parameter int COL_HOLD      = 1,
  parameter int ACCESS_CYC    = 2,
  parameter int PRECHARGE_CYC = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       rowHit,
  input  logic       curRead,
  input  logic       curLate,
  output dpStrobes_t strobes,
  output logic       rasN,
  output logic       casN,
  output logic       weN,
  output logic       oeN,
  output logic       doutEn,
  output logic       mfc
);
  localparam int CAS_LEN = (ACCESS_CYC > COL_HOLD) ? ACCESS_CYC : COL_HOLD;
  localparam int MAX_A   = (ROW_SETUP > ROW_HOLD) ? ROW_SETUP : ROW_HOLD;
  localparam int MAX_B   = (COL_SETUP > CAS_LEN) ? COL_SETUP : CAS_LEN;
  localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_LEN = (MAX_C > PRECHARGE_CYC) ? MAX_C : PRECHARGE_CYC;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  localparam logic [CNT_W-1:0] LD_RS  = CNT_W'(ROW_SETUP - 1);
  localparam logic [CNT_W-1:0] LD_RH  = CNT_W'(ROW_HOLD - 1);
  localparam logic [CNT_W-1:0] LD_CS  = CNT_W'(COL_SETUP - 1);
  localparam logic [CNT_W-1:0] LD_CAS = CNT_W'(CAS_LEN - 1);
  localparam logic [CNT_W-1:0] LD_PC  = CNT_W'(PRECHARGE_CYC - 1);
  localparam logic [CNT_W-1:0] CAP_AT = CNT_W'(CAS_LEN - ACCESS_CYC);

  ctlState_t        state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic             accept, colPhase, rowActive;

  assign accept = reqValid && (state == ST_IDLE || state == ST_ROW_OPEN);

  always_comb begin
    nextState = state;
    nextCnt   = (cnt != '0) ? cnt - 1'b1 : cnt;
    unique case (state)
      ST_IDLE:      if (accept) begin nextState = ST_ROW_SETUP; nextCnt = LD_RS; end
      ST_ROW_OPEN:
        if (accept) begin
          if (rowHit) begin nextState = ST_COL_SETUP; nextCnt = LD_CS; end
          else        begin nextState = ST_PRECHG;    nextCnt = LD_PC; end
        end
      ST_PRECHG:    if (cnt == '0) begin nextState = ST_ROW_SETUP; nextCnt = LD_RS;  end
      ST_ROW_SETUP: if (cnt == '0) begin nextState = ST_ROW_HOLD;  nextCnt = LD_RH;  end
      ST_ROW_HOLD:  if (cnt == '0) begin nextState = ST_COL_SETUP; nextCnt = LD_CS;  end
      ST_COL_SETUP: if (cnt == '0) begin nextState = ST_CAS_LOW;   nextCnt = LD_CAS; end
      ST_CAS_LOW:   if (cnt == '0) begin nextState = ST_DONE;      nextCnt = '0;     end
      ST_DONE:      nextState = ST_ROW_OPEN;
      default:      nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
    end
  end

  assign rowActive = (state == ST_ROW_HOLD) || (state == ST_COL_SETUP) ||
                     (state == ST_CAS_LOW)  || (state == ST_DONE) ||
                     (state == ST_ROW_OPEN);
  assign colPhase  = (state == ST_COL_SETUP) || (state == ST_CAS_LOW);

  assign rasN   = !rowActive;
  assign casN   = (state != ST_CAS_LOW);
  assign weN    = !(colPhase && !curRead);
  assign doutEn = colPhase && !curRead;
  assign oeN    = !(curRead && ((!curLate && colPhase) ||
                               (curLate && state == ST_CAS_LOW && cnt != LD_CAS)));
  assign mfc    = (state == ST_DONE);

  assign strobes.latchReq    = accept;
  assign strobes.selCol      = colPhase || (state == ST_DONE) || (state == ST_ROW_OPEN);
  assign strobes.captureData = (state == ST_CAS_LOW) && (cnt == CAP_AT) && curRead;

endmodule

// File: rtl/dram_timing_ctrl.sv
module dram_timing_ctrl
  import dram_timing_pkg::*;
#(
  parameter int ROW_BITS      = 12,
  parameter int COL_BITS      = 9,
  parameter int DATA_BITS     = 8,
  parameter int ROW_SETUP     = 1,
  parameter int ROW_HOLD      = 1,
  parameter int COL_SETUP     = 1,
  parameter int COL_HOLD      = 1,
  parameter int ACCESS_CYC    = 2,
  parameter int PRECHARGE_CYC = 2,
  localparam int ADDR_BITS    = ROW_BITS + COL_BITS,
  localparam int MUX_BITS     = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqRw,
  input  logic [ADDR_BITS-1:0] reqAddr,
  input  logic [DATA_BITS-1:0] reqWdata,
  input  logic                 lateRead,
  output logic [DATA_BITS-1:0] rdData,
  output logic                 mfc,
  output logic [MUX_BITS-1:0]  dramAddr,
  output logic                 dramRasN,
  output logic                 dramCasN,
  output logic                 dramWeN,
  output logic                 dramOeN,
  output logic [DATA_BITS-1:0] dramDout,
  output logic                 dramDoutEn,
  input  logic [DATA_BITS-1:0] dramDin
);
  dpStrobes_t strobes;
  logic       rowHit, curRead, curLate;

  dram_timing_fsm #(
    .ROW_SETUP(ROW_SETUP), .ROW_HOLD(ROW_HOLD), .COL_SETUP(COL_SETUP),
    .COL_HOLD(COL_HOLD), .ACCESS_CYC(ACCESS_CYC), .PRECHARGE_CYC(PRECHARGE_CYC)
  ) uFsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .rowHit(rowHit),
    .curRead(curRead), .curLate(curLate), .strobes(strobes),
    .rasN(dramRasN), .casN(dramCasN), .weN(dramWeN), .oeN(dramOeN),
    .doutEn(dramDoutEn), .mfc(mfc)
  );

  dram_timing_dp #(
    .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DATA_BITS(DATA_BITS), .MUX_BITS(MUX_BITS)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqRw(reqRw), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .lateRead(lateRead), .dramDin(dramDin), .rowHit(rowHit),
    .curRead(curRead), .curLate(curLate), .dramAddr(dramAddr), .dramDout(dramDout),
    .rdData(rdData)
  );

endmodule

// File: rtl/dram_timing_chk.sv
module dram_timing_chk #(
  parameter int MUX_BITS = 12
) (
  input logic                clk,
  input logic                rstN,
  input logic                rasN,
  input logic                casN,
  input logic                weN,
  input logic                oeN,
  input logic                doutEn,
  input logic                mfc,
  input logic                lateRead,
  input logic [MUX_BITS-1:0] addr
);
  // R1
  rst_idle_chk: assert property (@(posedge clk) !rstN |-> rasN && casN && weN && oeN && !mfc && !doutEn);

  // R2
  cas_in_row_chk: assert property (@(posedge clk) disable iff (!rstN) !casN |-> !rasN);

  // R3
  row_addr_window_chk: assert property (@(posedge clk) disable iff (!rstN) $fell(rasN) |-> $stable(addr));

  // R4
  col_addr_window_chk: assert property (@(posedge clk) disable iff (!rstN) $fell(casN) |-> $stable(addr));

  // R5
  early_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(casN) && weN && !lateRead) |-> (!oeN && !$past(oeN)));

  // R6
  late_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(casN) && weN && lateRead) |-> oeN);

  // R8
  write_no_oe_chk: assert property (@(posedge clk) disable iff (!rstN) !weN |-> (oeN && doutEn));

  // R9
  mfc_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) mfc |=> !mfc);

  // R11
  precharge_chk: assert property (@(posedge clk) disable iff (!rstN) $rose(rasN) |=> rasN);

endmodule

bind dram_timing_ctrl dram_timing_chk #(.MUX_BITS(MUX_BITS)) uChk (
  .clk(clk), .rstN(rstN), .rasN(dramRasN), .casN(dramCasN), .weN(dramWeN),
  .oeN(dramOeN), .doutEn(dramDoutEn), .mfc(mfc), .lateRead(lateRead), .addr(dramAddr)
);

// File: tb/sim_dram_timing_ctrl.sv
module sim_dram_timing_ctrl;
  localparam int RB = 3, CB = 3, DB = 8;
  localparam int RS = 2, RH = 2, CS = 2, CH = 1, ACC = 3, PC = 2;
  localparam int CL = (ACC > CH) ? ACC : CH;
  localparam int L_CLOSED = 1 + RS + RH + CS + CL;
  localparam int L_PAGE   = 1 + CS + CL;
  localparam int L_MISS   = L_CLOSED + PC;
  localparam int NADDR    = 1 << (RB + CB);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqRw = 1'b1, lateRead = 1'b0;
  logic [RB+CB-1:0] reqAddr = '0;
  logic [DB-1:0] reqWdata = '0;
  logic [DB-1:0] rdData, dramDout, dramDin;
  logic mfc, dramRasN, dramCasN, dramWeN, dramOeN, dramDoutEn;
  logic [CB-1:0] dramAddr;

  int checks = 0, fails = 0;
  int openRowB = -1;
  logic [DB-1:0] expMem [NADDR];

  always #10 clk = ~clk;

  dram_timing_ctrl #(
    .ROW_BITS(RB), .COL_BITS(CB), .DATA_BITS(DB), .ROW_SETUP(RS), .ROW_HOLD(RH),
    .COL_SETUP(CS), .COL_HOLD(CH), .ACCESS_CYC(ACC), .PRECHARGE_CYC(PC)
  ) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRw(reqRw), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .lateRead(lateRead), .rdData(rdData), .mfc(mfc),
    .dramAddr(dramAddr), .dramRasN(dramRasN), .dramCasN(dramCasN), .dramWeN(dramWeN),
    .dramOeN(dramOeN), .dramDout(dramDout), .dramDoutEn(dramDoutEn), .dramDin(dramDin)
  );

  // behavioural memory: row latched on row strobe fall, column on column strobe fall
  logic [DB-1:0] mem [NADDR];
  logic [RB-1:0] rowLat = '0;
  logic [CB-1:0] colLat = '0;
  initial for (int i = 0; i < NADDR; i++) mem[i] = '0;
  always @(negedge dramRasN) rowLat = dramAddr;
  always @(negedge dramCasN) begin
    colLat = dramAddr;
    if (!dramWeN) mem[{rowLat, dramAddr}] = dramDout;
  end
  assign dramDin = (!dramCasN && !dramOeN) ? mem[{rowLat, colLat}] : '0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // port monitor
  logic prevRas = 1'b1, prevCas = 1'b1, prevOe = 1'b1;
  logic [CB-1:0] prevAddr = '0;
  int runLen = 0, holdCnt = 0, rasRises = 0;
  bit holdActive = 0, latePend = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (dramAddr == prevAddr) runLen++; else runLen = 1;
      if (prevRas && !dramRasN) begin
        chk(runLen - 1 >= RS, "R3 row setup", runLen - 1, RS);
        holdActive = 1; holdCnt = 1;
      end else if (holdActive) begin
        if (dramAddr == prevAddr && !dramRasN) holdCnt++;
        else begin chk(holdCnt >= RH, "R3 row hold", holdCnt, RH); holdActive = 0; end
      end
      if (prevCas && !dramCasN) begin
        chk(runLen - 1 >= CS, "R4 col setup", runLen - 1, CS);
        if (dramWeN) begin
          if (lateRead) begin chk(dramOeN == 1'b1, "R6 OE high at CAS fall", dramOeN, 1); latePend = 1; end
          else chk(!dramOeN && !prevOe, "R5 OE before CAS", {prevOe, dramOeN}, 0);
        end else chk(dramOeN && dramDoutEn, "R8 write drive", {dramOeN, dramDoutEn}, 3);
      end else if (latePend) begin
        chk(dramOeN == 1'b0, "R6 OE low after CAS", dramOeN, 0);
        latePend = 0;
      end
      if (!prevRas && dramRasN) rasRises++;
      prevRas = dramRasN; prevCas = dramCasN; prevOe = dramOeN; prevAddr = dramAddr;
    end
  end

  function automatic int expLat(input int a);
    int r = a >> CB;
    int l = (openRowB < 0) ? L_CLOSED : ((r == openRowB) ? L_PAGE : L_MISS);
    openRowB = r;
    return l;
  endfunction

  task automatic doAccess(input bit rw, input int a, input logic [DB-1:0] wd,
                          output int lat, output logic [DB-1:0] rd);
    reqValid = 1'b1; reqRw = rw; reqAddr = a[RB+CB-1:0]; reqWdata = wd;
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0; lat = 1;
    while (!mfc && lat < 200) begin @(posedge clk); @(negedge clk); lat++; end
    rd = rdData;
    @(posedge clk); @(negedge clk);
    chk(!mfc, "R9 single-cycle completion", mfc, 0);
  endtask

  task automatic finishRun;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    int lat, el, r0;
    logic [DB-1:0] rd;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(dramRasN && dramCasN && dramWeN && dramOeN && !mfc && !dramDoutEn, "R1 reset outputs",
        {dramRasN, dramCasN, dramWeN, dramOeN, mfc, dramDoutEn}, 60);
    rstN = 1'b1;
    @(negedge clk);
    chk(dramRasN && dramCasN && !mfc, "R1 after reset", {dramRasN, dramCasN, mfc}, 6);

    // write every address in order: closed, page hits, row misses (R2 R8 R9 R10 R11)
    for (int a = 0; a < NADDR; a++) begin
      expMem[a] = 8'(a * 37 + 5);
      el = expLat(a);
      if (a == 1) r0 = rasRises;
      doAccess(1'b0, a, expMem[a], lat, rd);
      chk(lat == el, (el == L_PAGE) ? "R10 page latency" : (el == L_MISS) ? "R11 miss latency" : "R9 closed latency", lat, el);
      if (a == 7) chk(rasRises == r0, "R10 row strobe held in burst", rasRises - r0, 0);
    end

    // read back in order, early output enable (R2 R5 R7)
    lateRead = 1'b0;
    for (int a = 0; a < NADDR; a++) begin
      el = expLat(a);
      doAccess(1'b1, a, 8'h00, lat, rd);
      chk(rd == expMem[a], "R7 R2 early read data", rd, expMem[a]);
      chk(lat == el, "R9 R10 R11 read latency", lat, el);
    end

    // scattered read order, late output enable (R6 R7)
    lateRead = 1'b1;
    for (int i = 0; i < NADDR; i++) begin
      int a = (i * 13 + 5) % NADDR;
      el = expLat(a);
      doAccess(1'b1, a, 8'h00, lat, rd);
      chk(rd == expMem[a], "R7 R6 late read data", rd, expMem[a]);
      chk(lat == el, "R11 scattered latency", lat, el);
    end
    lateRead = 1'b0;

    // R12: request while busy is ignored
    begin
      int mfcCount = 0;
      reqValid = 1'b1; reqRw = 1'b0; reqAddr = 6'd9; reqWdata = 8'hAA;
      @(posedge clk); @(negedge clk);
      reqValid = 1'b0;
      repeat (2) @(negedge clk);
      reqValid = 1'b1; reqRw = 1'b0; reqAddr = 6'd20; reqWdata = 8'h55;
      @(posedge clk); @(negedge clk);
      reqValid = 1'b0;
      for (int k = 0; k < 40; k++) begin
        if (mfc) mfcCount++;
        @(negedge clk);
      end
      chk(mfcCount == 1, "R12 one completion for busy request", mfcCount, 1);
      expMem[9] = 8'hAA;
      openRowB = 9 >> CB;
    end
    doAccess(1'b1, 20, 8'h00, lat, rd);
    chk(rd == expMem[20], "R12 ignored write left memory", rd, expMem[20]);
    doAccess(1'b1, 9, 8'h00, lat, rd);
    chk(rd == 8'hAA, "R8 accepted write landed", rd, 8'hAA);

    // R7: write does not disturb held read data
    doAccess(1'b0, 10, 8'h3C, lat, rd);
    chk(rdData == 8'hAA, "R7 read data held across write", rdData, 8'hAA);
    repeat (5) @(negedge clk);
    chk(rdData == 8'hAA, "R7 read data held while idle", rdData, 8'hAA);

    finishRun();
  end

endmodule